// File: doc/BRIEF.md
# Card-Detect Debounce and Hotplug Notifier

This block watches a mechanical card-detect contact that pulls low while a card sits in the slot. The raw pin is brought into the clock domain through a chain of flops. Any change of the synchronised level, rising or falling, arms a one-shot stability timer. If the timer is already running, the change starts it again from zero. The block does not care which way the change went. When the window ends without another change, the block reads the current level. If that level differs from the state it last reported, it emits a one-cycle insertion or removal pulse. Contact bounce therefore collapses into at most one event, and a short glitch that returns to the old level gives no event.

Alongside the pulses, the block drives a `card_present` level and a sticky change flag. Every synchronised edge sets the flag. It stays set until a clear strobe is written, and it reaches the `irq` pin only while the enable input is high. The window length is given in clock cycles. By default it is computed from the clock frequency and a 300 ms settling time. After reset the timer is already armed, so the state of the slot is reported once the first window has passed.

Top module: `cd_debounce_top`

## Requirements
- R1: During and right after reset, `card_present`, `insert_pulse`, `remove_pulse` and `irq` are all 0.
- R2: `card_det_n` is active low: 0 means a card is present. A low level that stays stable for a full window produces an `insert_pulse`, and `card_present` goes to 1 on the same clock edge.
- R3: With SYNC_STAGES flops in the synchroniser, the event pulse appears SYNC_STAGES + STABLE_CYCLES + 2 rising clock edges after the raw input changes. The edge that first samples the new value counts as edge 1.
- R4: Every synchronised edge, in either direction, restarts the window from zero. No event can appear until a full window has passed after the last edge.
- R5: The event is decided only by the level at the moment the window expires. If that level equals the last reported state, no event is emitted and `card_present` is unchanged.
- R6: A high level (no card) that stays stable for a full window, while a card was reported, produces a `remove_pulse`, and `card_present` drops to 0 on the same edge.
- R7: `insert_pulse` and `remove_pulse` are each exactly one cycle wide and are never high together.
- R8: Every synchronised edge sets the sticky change flag. The flag stays set, whatever the level does, until a clear strobe arrives.
- R9: A one-cycle pulse on `irq_clr` clears the flag on the next clock edge. If an edge arrives in the same cycle as the clear, the set wins.
- R10: `irq` is a registered copy of the flag gated by `irq_en`, and it updates one clock edge after either of them changes. While `irq_en` is 0, `irq` stays 0.
- R11: If a card is already inserted when reset is released, `insert_pulse` appears SYNC_STAGES + STABLE_CYCLES + 2 edges after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| card_det_n | input | 1 | Raw card-detect contact, low while a card is present |
| irq_en | input | 1 | Lets the sticky flag through to `irq` |
| irq_clr | input | 1 | One-cycle write strobe that clears the sticky flag |
| card_present | output | 1 | Debounced presence state last reported |
| insert_pulse | output | 1 | One-cycle insertion event |
| remove_pulse | output | 1 | One-cycle removal event |
| irq | output | 1 | Sticky change flag gated by the enable |

## Verification
The bench changes `card_det_n` on a falling clock edge and then counts rising edges. It expects the event pulse at exactly edge SYNC_STAGES + STABLE_CYCLES + 2, with nothing before it and only one pulse in total. For the retrigger, glitch and duplicate cases, it watches the pulse outputs over the whole window and checks that nothing appears early. The flag is expected on `irq` one edge after the edge that reaches the end of the synchroniser, and a clear takes effect on the edge that follows the strobe. The bench places the clear strobe in that edge's cycle on purpose, to show that the set wins. Every port is sampled on falling edges, half a period after the rising edge that updates it.

// File: rtl/cd_pkg.sv
package cd_pkg;
  typedef enum logic [1:0] {
    CD_EV_NONE   = 2'd0,
    CD_EV_INSERT = 2'd1,
    CD_EV_REMOVE = 2'd2
  } cd_evt_e;
endpackage

// File: rtl/cd_sync_edge.sv
module cd_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic level_o,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= raw_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[SYNC_STAGES-1];
  end

  assign level_o = chain_q[SYNC_STAGES-1];
  assign edge_o  = chain_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/cd_stab_timer.sv
module cd_stab_timer #(
  parameter int unsigned STABLE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      armed_q  <= 1'b1;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (restart) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q == LAST) begin
          armed_q  <= 1'b0;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (cnt_q <= LAST)); // R3
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0 && armed_q && !expire_o)); // R4
endmodule

// File: rtl/cd_event_gen.sv
module cd_event_gen
  import cd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic level_n,
  output logic present_o,
  output logic ins_o,
  output logic rem_o
);
  cd_evt_e evt_q;
  logic    seen_present;

  assign seen_present = ~level_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      present_o <= 1'b0;
      evt_q     <= CD_EV_NONE;
    end else begin
      evt_q <= CD_EV_NONE;
      if (expire && (seen_present != present_o)) begin
        present_o <= seen_present;
        evt_q     <= seen_present ? CD_EV_INSERT : CD_EV_REMOVE;
      end
    end
  end

  assign ins_o = (evt_q == CD_EV_INSERT);
  assign rem_o = (evt_q == CD_EV_REMOVE);

  AST_INS_SETS_PRESENT: assert property (@(posedge clk) disable iff (rst)
    ins_o |-> present_o); // R2
  AST_REM_CLEARS_PRESENT: assert property (@(posedge clk) disable iff (rst)
    rem_o |-> !present_o); // R6
  AST_PRESENT_HELD: assert property (@(posedge clk) disable iff (rst)
    !expire |=> $stable(present_o)); // R5
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ins_o, rem_o})); // R7
  AST_INS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ins_o |=> !ins_o); // R7
endmodule

// File: rtl/cd_irq_flag.sv
module cd_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic irq_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_o  <= flag_d & en;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> flag_q); // R9
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_o); // R10
endmodule

// File: rtl/cd_debounce_top.sv
module cd_debounce_top #(
  parameter int unsigned CLK_HZ        = 250_000_000,
  parameter int unsigned WINDOW_MS     = 300,
  parameter int unsigned STABLE_CYCLES = CLK_HZ / 1000 * WINDOW_MS,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic card_det_n,
  input  logic irq_en,
  input  logic irq_clr,
  output logic card_present,
  output logic insert_pulse,
  output logic remove_pulse,
  output logic irq
);
  logic sync_level;
  logic sync_edge;
  logic expire;

  cd_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .raw_in  (card_det_n),
    .level_o (sync_level),
    .edge_o  (sync_edge)
  );

  cd_stab_timer #(.STABLE_CYCLES(STABLE_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (sync_edge),
    .expire_o (expire)
  );

  cd_event_gen u_event (
    .clk       (clk),
    .rst       (rst),
    .expire    (expire),
    .level_n   (sync_level),
    .present_o (card_present),
    .ins_o     (insert_pulse),
    .rem_o     (remove_pulse)
  );

  cd_irq_flag u_irq (
    .clk   (clk),
    .rst   (rst),
    .set   (sync_edge),
    .clr   (irq_clr),
    .en    (irq_en),
    .irq_o (irq)
  );

  AST_EVT_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    (insert_pulse || remove_pulse) |-> $past(expire)); // R5
endmodule

// File: tb/cd_debounce_top_tb_top.sv
`timescale 1ns/1ps
module cd_debounce_top_tb_top;
  localparam int L   = 40;
  localparam int SS  = 2;
  localparam int LAT = SS + L + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic card_det_n = 1'b1;
  logic irq_en = 1'b0;
  logic irq_clr = 1'b0;
  logic card_present, insert_pulse, remove_pulse, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cd_debounce_top #(.STABLE_CYCLES(L), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst(rst), .card_det_n(card_det_n), .irq_en(irq_en),
    .irq_clr(irq_clr), .card_present(card_present),
    .insert_pulse(insert_pulse), .remove_pulse(remove_pulse), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 insert, 2 remove, 3 both
  task automatic watch(input int maxc, output int first, output int kind, output int nevt);
    first = -1; kind = 0; nevt = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk); @(negedge clk);
      if (insert_pulse || remove_pulse) begin
        nevt++;
        if (first < 0) begin
          first = i;
          kind = (insert_pulse && remove_pulse) ? 3 : (insert_pulse ? 1 : 2);
        end
      end
    end
  endtask

  task automatic pulse_clear();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    int f, k, n;
    chk(card_present == 0 && insert_pulse == 0 && remove_pulse == 0 && irq == 0,
        "R1 reset outputs", {card_present, insert_pulse, remove_pulse, irq}, 0);
    @(negedge clk); rst = 1'b0;
    watch(LAT + 8, f, k, n);
    chk(n == 0, "R1 no event with empty slot after reset", n, 0);
    chk(card_present == 0, "R1 present low after reset", card_present, 0);
  endtask

  task automatic t_insert();
    int f, k, n;
    irq_en = 1'b1;
    card_det_n = 1'b0;
    watch(LAT + 8, f, k, n);
    chk(f == LAT, "R3 insert latency", f, LAT);
    chk(k == 1, "R2 insert on low level", k, 1);
    chk(n == 1, "R7 single-cycle insert pulse", n, 1);
    chk(card_present == 1, "R2 present after insert", card_present, 1);
    chk(irq == 1, "R8 flag set by edge", irq, 1);
    pulse_clear();
    chk(irq == 0, "R9 clear drops flag", irq, 0);
  endtask

  task automatic t_glitch();
    int f, k, n;
    card_det_n = 1'b1;
    repeat (3) @(negedge clk);
    card_det_n = 1'b0;
    watch(2 * LAT, f, k, n);
    chk(n == 0, "R5 glitch back to old level gives no event", n, 0);
    chk(card_present == 1, "R5 present unchanged by glitch", card_present, 1);
    chk(irq == 1, "R8 glitch edge latched in flag", irq, 1);
    repeat (5) @(negedge clk);
    chk(irq == 1, "R8 flag sticky without clear", irq, 1);
    pulse_clear();
  endtask

  task automatic t_retrigger();
    int f, k, n;
    card_det_n = 1'b1;
    watch(L / 2, f, k, n);
    chk(n == 0, "R4 no event mid-window 1", n, 0);
    card_det_n = 1'b0;
    watch(L / 2, f, k, n);
    chk(n == 0, "R4 no event mid-window 2", n, 0);
    card_det_n = 1'b1;
    watch(LAT + 8, f, k, n);
    chk(f == LAT, "R4 window restarted by last edge", f, LAT);
    chk(k == 2, "R6 removal on high level", k, 2);
    chk(n == 1, "R7 single removal pulse", n, 1);
    chk(card_present == 0, "R6 present cleared", card_present, 0);
    pulse_clear();
  endtask

  task automatic t_mask();
    int f, k, n;
    irq_en = 1'b0;
    card_det_n = 1'b0;
    watch(LAT + 4, f, k, n);
    chk(irq == 0, "R10 masked irq stays low", irq, 0);
    chk(k == 1, "R2 insert while masked", k, 1);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1, "R10 irq follows enable one edge later", irq, 1);
  endtask

  task automatic t_set_wins();
    int f, k, n;
    pulse_clear();
    chk(irq == 0, "R9 flag cleared before race", irq, 0);
    card_det_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq == 1, "R9 set wins over simultaneous clear", irq, 1);
    watch(LAT + 4, f, k, n);
    chk(k == 2 && n == 1, "R6 removal after race", k, 2);
  endtask

  task automatic t_reset_present();
    int f, k, n;
    @(negedge clk);
    rst = 1'b1;
    card_det_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(card_present == 0 && irq == 0, "R1 reset clears state", card_present, 0);
    rst = 1'b0;
    watch(LAT + 8, f, k, n);
    chk(f == LAT, "R11 insert latency from reset release", f, LAT);
    chk(k == 1 && n == 1, "R11 single insert after reset", k, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_insert();
    t_glitch();
    t_retrigger();
    t_mask();
    t_set_wins();
    t_reset_present();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule